// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is a memory-mapped controller for 28 general-purpose pins. For each pin it keeps three control bits: the level driven onto the pad, whether the pad driver is on, and whether the pad's input is passed to software. The pins are split into two banks of up to 16. Lines 0 to 15 sit in the low bank. Lines 16 to 27 sit in the high bank, whose register window is the low bank's window moved up by 0x80.

Every control register is written as a pair of 16-bit masks. A 1 in the lower half turns a bit on for the matching local line. A 1 in the upper half turns it off. A 0 in either half leaves the line alone. Software can therefore change any subset of lines in one write, with no read-modify-write and no lock. A fourth, read-only register per bank returns the pad levels after a two-flop synchronizer. Lines whose input is disabled read as 0 there.

Top module: `pinbank_ctrl`

## Requirements
- R1: Register offsets within a bank are 0x00 output level (driven on `pad_out`), 0x04 driver enable (driven on `pad_oe`), 0x08 input enable and 0x0C input value (read-only). The low bank covers lines 0–15 at 0x00–0x0C, with local bit j mapping to line j. The high bank covers lines 16–27 at 0x80–0x8C, with local bit j mapping to line 16+j.
- R2: In a write to a writable register, a 1 in bit j (0..15) sets that bit for local line j. The change shows on the pad outputs after the write's clock edge.
- R3: In a write to a writable register, a 1 in bit j+16 clears that bit for local line j.
- R4: When bit j and bit j+16 are both 1 in one write, the line's bit ends up 0.
- R5: Lines whose set and clear bits are both 0 keep their state. Without a write strobe, no control bit changes.
- R6: High-bank local bits 12–15 map to no line. Writes to them do nothing and they always read 0.
- R7: A read strobe on a mapped address makes `bus_rdata` hold that register's value one cycle later, with line state in bits 0–15 and bits 16–31 zero. In a cycle that follows no read of a mapped address, `bus_rdata` is 0. A read that coincides with a write returns the value from before the write.
- R8: Reading 0x0C or 0x8C returns `pad_in` after two register stages, ANDed with each line's input enable. The level is the one `pad_in` had two edges before the edge that captures the read.
- R9: While `rst_n` is low at a clock edge, every control bit, both synchronizer stages and `bus_rdata` become 0.
- R10: Writes to the input-value register, to offsets other than 0x00/0x04/0x08 (including non-word-aligned ones) or to anything outside the two windows change nothing. Reads of such unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write word: clear mask in 31:16, set mask in 15:0 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_rdata | output | 32 | Registered read data |
| pad_out | output | 28 | Level driven onto each pad |
| pad_oe | output | 28 | Pad driver enable per line |
| pad_in | input | 28 | Asynchronous pad levels |

## Verification
The assertions assume that the bus inputs carry known values at every clock edge from the first reset cycle onward. A strobe is taken to mean one access in the cycle it is high, and reads and writes may share a cycle. `pad_in` is treated as asynchronous, so no property depends on its value. The stimulus drives every input from the first cycle. It changes the inputs only on the falling clock edge, keeps them free of X, and randomizes `pad_in` and the bus fields while staying inside the 8-bit address space.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
// pinbank_pkg
// Shared types and the register-offset decoder for the pin bank controller.
// Assumes a bank window of 2**BANK_WIN_LOG2 bytes and 32-bit word registers.
package pinbank_pkg;

    // Bank window size as a power of two (0x80 bytes)
    localparam int BANK_WIN_LOG2 = 7;

    // Per-line control or status selected by a register offset
    typedef enum logic [1:0] {
        FEAT_OUTLVL = 2'd0,
        FEAT_DRVEN  = 2'd1,
        FEAT_INEN   = 2'd2,
        FEAT_INVAL  = 2'd3
    } feat_e;

    // Result of decoding the offset inside one bank window
    typedef struct packed {
        logic  hit;
        logic  writable;
        feat_e feat;
    } dec_t;

    // Map an in-window byte offset onto a register, rejecting anything else
    function automatic dec_t decode_offset(input logic [BANK_WIN_LOG2-1:0] off);
        dec_t d;
        d.hit      = 1'b1;
        d.writable = 1'b1;
        d.feat     = FEAT_OUTLVL;
        case (off)
            7'h00: d.feat = FEAT_OUTLVL;
            7'h04: d.feat = FEAT_DRVEN;
            7'h08: d.feat = FEAT_INEN;
            7'h0C: begin
                d.feat     = FEAT_INVAL;
                d.writable = 1'b0;
            end
            default: begin
                d.hit      = 1'b0;
                d.writable = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
// pinbank_sync
// Two-stage synchronizer for asynchronous pad levels.
// Assumes each bit is independent; no cross-bit coherence is promised.
module pinbank_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;

    // Capture the raw pads, then re-register to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end

endmodule

// File: rtl/pinbank_setclr.sv
`timescale 1ns/1ps
// pinbank_setclr
// One control register whose bits are set and cleared by separate masks.
// Assumes the masks are only meaningful while wr_en is high; clear wins.
module pinbank_setclr #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] set_bits,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] state_q
);

    // Apply set then clear so a line named in both masks ends up cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (wr_en) begin
            state_q <= (state_q | set_bits) & ~clr_bits;
        end
    end

endmodule

// File: rtl/pinbank_bank.sv
`timescale 1ns/1ps
// pinbank_bank
// One bank of up to SLOT_W lines: three set/clear control registers, the
// input gating and the zero-padded read slot for the selected register.
// Assumes LINES <= SLOT_W; slot bits above LINES read as zero.
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  feat_e             wr_feat,
    input  logic [LINES-1:0]  set_bits,
    input  logic [LINES-1:0]  clr_bits,
    input  logic [LINES-1:0]  pin_sync,
    input  feat_e             rd_feat,
    output logic [LINES-1:0]  line_out,
    output logic [LINES-1:0]  line_oe,
    output logic [SLOT_W-1:0] rd_slot
);

    localparam int NUM_CTRL = 3;

    logic [LINES-1:0] ctrl_q [NUM_CTRL];
    logic [LINES-1:0] in_gated;

    // One set/clear register per writable control kind
    for (genvar f = 0; f < NUM_CTRL; f++) begin : g_ctrl
        pinbank_setclr #(
            .WIDTH (LINES)
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_feat == feat_e'(f))),
            .set_bits (set_bits),
            .clr_bits (clr_bits),
            .state_q  (ctrl_q[f])
        );
    end

    assign line_out = ctrl_q[FEAT_OUTLVL];
    assign line_oe  = ctrl_q[FEAT_DRVEN];
    assign in_gated = pin_sync & ctrl_q[FEAT_INEN];

    // Select the requested register and pad it to the slot width
    always_comb begin
        rd_slot = '0;
        case (rd_feat)
            FEAT_OUTLVL: rd_slot[LINES-1:0] = ctrl_q[FEAT_OUTLVL];
            FEAT_DRVEN:  rd_slot[LINES-1:0] = ctrl_q[FEAT_DRVEN];
            FEAT_INEN:   rd_slot[LINES-1:0] = ctrl_q[FEAT_INEN];
            default:     rd_slot[LINES-1:0] = in_gated;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
`timescale 1ns/1ps
// pinbank_ctrl
// Top of the pin bank controller: decodes the register bus, builds one bank
// per SLOT_W lines, synchronizes the pads and registers the read data.
// Assumes single-cycle strobes and a window of 0x80 bytes per bank.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_LINES = 28,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    input  logic [NUM_LINES-1:0] pad_in
);

    localparam int SLOT_W    = DATA_W / 2;
    localparam int NUM_BANKS = (NUM_LINES + SLOT_W - 1) / SLOT_W;
    localparam int SEL_W     = ADDR_W - BANK_WIN_LOG2;

    dec_t                 dec;
    logic [SEL_W-1:0]     bank_sel;
    logic                 bank_ok;
    logic                 wr_go;
    logic                 rd_go;
    logic [NUM_LINES-1:0] pin_sync;
    logic [SLOT_W-1:0]    bank_rd [NUM_BANKS];

    assign dec      = decode_offset(bus_addr[BANK_WIN_LOG2-1:0]);
    assign bank_sel = bus_addr[ADDR_W-1:BANK_WIN_LOG2];
    assign bank_ok  = (int'(bank_sel) < NUM_BANKS);
    assign wr_go    = bus_wr && dec.hit && dec.writable && bank_ok;
    assign rd_go    = bus_rd && dec.hit && bank_ok;

    pinbank_sync #(
        .WIDTH (NUM_LINES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // One bank per SLOT_W lines; the last bank may be partly populated
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO  = b * SLOT_W;
        localparam int CNT = (NUM_LINES - LO > SLOT_W) ? SLOT_W : NUM_LINES - LO;

        pinbank_bank #(
            .LINES  (CNT),
            .SLOT_W (SLOT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_go && (bank_sel == SEL_W'(b))),
            .wr_feat  (dec.feat),
            .set_bits (bus_wdata[CNT-1:0]),
            .clr_bits (bus_wdata[SLOT_W+CNT-1:SLOT_W]),
            .pin_sync (pin_sync[LO+CNT-1:LO]),
            .rd_feat  (dec.feat),
            .line_out (pad_out[LO+CNT-1:LO]),
            .line_oe  (pad_oe[LO+CNT-1:LO]),
            .rd_slot  (bank_rd[b])
        );
    end

    // Return the selected slot one cycle after a mapped read, else zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_go) begin
            bus_rdata <= {{(DATA_W-SLOT_W){1'b0}}, bank_rd[bank_sel]};
        end else begin
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/pinbank_checker.sv
`timescale 1ns/1ps
// pinbank_checker
// Properties over the ports of pinbank_ctrl, attached by bind.
// Assumes the default layout: bank window bit 7, driver enable at 0x04.
module pinbank_checker #(
    parameter int NUM_LINES = 28,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_out) && $stable(pad_oe))); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h04)) |=>
        (pad_oe[15:0] == (($past(pad_oe[15:0]) | $past(bus_wdata[15:0])) & ~$past(bus_wdata[31:16])))); // R4

    AST_UNMAPPED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[1:0] != 2'b00 || bus_addr[6:4] != 3'b000 || bus_addr[3:2] == 2'b11)) |=>
        ($stable(pad_out) && $stable(pad_oe))); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:DATA_W/2] == '0); // R7

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R7

    AST_HIGH_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[7]) |=> (bus_rdata[15:12] == '0)); // R6

endmodule

bind pinbank_ctrl pinbank_checker #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_pinbank_checker (.*);

// File: tb/pinbank_ctrl_bench.sv
`timescale 1ns/1ps
// pinbank_ctrl_bench
// Behavioural per-line reference model, compared with the ports every cycle.
module pinbank_ctrl_bench;

    localparam int NL = 28;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_wr;
    logic          bus_rd;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_out;
    logic [NL-1:0] pad_oe;
    logic [NL-1:0] pad_in;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R9";
    bit    checking = 1'b0;
    bit    finished = 1'b0;

    // reference model state, one entry per line
    bit    m_lvl [NL];
    bit    m_drv [NL];
    bit    m_ien [NL];
    bit    m_s1  [NL];
    bit    m_s2  [NL];
    logic [31:0] m_rdata;

    always #2.5 clk = ~clk;

    pinbank_ctrl u_pinbank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_in    (pad_in)
    );

    // register kind from address: 0 level, 1 driver, 2 input enable, 3 input value, -1 none
    function automatic int kind_of(input logic [7:0] a);
        case (a[6:0])
            7'h00: return 0;
            7'h04: return 1;
            7'h08: return 2;
            7'h0C: return 3;
            default: return -1;
        endcase
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin
        int k;
        int line;
        logic [31:0] nrd;
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                m_lvl[i] = 0; m_drv[i] = 0; m_ien[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
            end
            m_rdata = 32'h0;
        end else begin
            nrd = 32'h0;
            k = kind_of(bus_addr);
            if (bus_rd && k >= 0) begin
                for (int j = 0; j < 16; j++) begin
                    line = (bus_addr[7] ? 16 : 0) + j;
                    if (line < NL) begin
                        case (k)
                            0: nrd[j] = m_lvl[line];
                            1: nrd[j] = m_drv[line];
                            2: nrd[j] = m_ien[line];
                            default: nrd[j] = m_s2[line] & m_ien[line];
                        endcase
                    end
                end
            end
            if (bus_wr && k >= 0 && k < 3) begin
                for (int j = 0; j < 16; j++) begin
                    line = (bus_addr[7] ? 16 : 0) + j;
                    if (line < NL && (bus_wdata[j] || bus_wdata[j+16])) begin
                        case (k)
                            0: m_lvl[line] = !bus_wdata[j+16];
                            1: m_drv[line] = !bus_wdata[j+16];
                            default: m_ien[line] = !bus_wdata[j+16];
                        endcase
                    end
                end
            end
            for (int i = 0; i < NL; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = pad_in[i];
            end
            m_rdata = nrd;
        end
    end

    // compare ports with the model away from the active edge
    always @(negedge clk) begin
        logic [NL-1:0] e_out;
        logic [NL-1:0] e_oe;
        if (checking && !finished) begin
            for (int i = 0; i < NL; i++) begin
                e_out[i] = m_lvl[i];
                e_oe[i]  = m_drv[i];
            end
            total += 3;
            if (pad_out !== e_out) begin
                bad++;
                $display("FAIL %s pad_out got %h expected %h", cur_req, pad_out, e_out);
            end
            if (pad_oe !== e_oe) begin
                bad++;
                $display("FAIL %s pad_oe got %h expected %h", cur_req, pad_oe, e_oe);
            end
            if (bus_rdata !== m_rdata) begin
                bad++;
                $display("FAIL %s bus_rdata got %h expected %h", cur_req, bus_rdata, m_rdata);
            end
        end
    end

    // one bus cycle, driven on the falling edge
    task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = w;
        bus_rd    = r;
        bus_addr  = a;
        bus_wdata = d;
        pad_in    = NL'($urandom);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [7:0] a);
        op(1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic read_all();
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
        rd(8'h80); rd(8'h84); rd(8'h88); rd(8'h8C);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got running expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        bus_addr  = 8'h00;
        bus_wdata = 32'h0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        pad_in    = '0;
        @(posedge clk);
        checking = 1'b1;
        do_reset(3);

        cur_req = "R9";   // reset state on every register
        read_all();

        cur_req = "R2";   // set bits in the low bank
        wr(8'h04, 32'h0000_0005);
        wr(8'h00, 32'h0000_8001);
        read_all();

        cur_req = "R3";   // clear through the upper half
        wr(8'h00, 32'h0001_0000);
        wr(8'h04, 32'h0004_0000);
        read_all();

        cur_req = "R4";   // set and clear together
        wr(8'h04, 32'h00FF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        read_all();

        cur_req = "R5";   // zero masks and idle cycles
        wr(8'h04, 32'h0000_0000);
        idle(4);
        read_all();

        cur_req = "R1";   // high bank window
        wr(8'h84, 32'h0000_0A5A);
        wr(8'h80, 32'h0000_0FF0);
        read_all();

        cur_req = "R6";   // missing lines at the top of the high bank
        wr(8'h84, 32'h0000_F000);
        wr(8'h80, 32'h0000_FFFF);
        rd(8'h84);
        wr(8'h80, 32'hF000_0000);
        read_all();

        cur_req = "R8";   // synchronized, gated input values
        wr(8'h08, 32'h0000_00FF);
        wr(8'h88, 32'h0000_0F0F);
        for (int i = 0; i < 20; i++) begin
            rd(8'h0C);
            rd(8'h8C);
        end
        wr(8'h08, 32'hFFFF_0000);
        for (int i = 0; i < 6; i++) rd(8'h0C);

        cur_req = "R10";  // unmapped and read-only targets
        wr(8'h0C, 32'h0000_FFFF);
        wr(8'h10, 32'h0000_FFFF);
        wr(8'h02, 32'h0000_FFFF);
        wr(8'h8D, 32'h0000_FFFF);
        wr(8'hFC, 32'hFFFF_0000);
        wr(8'h7C, 32'h0000_FFFF);
        rd(8'h10); rd(8'h02); rd(8'h7C); rd(8'h85);
        read_all();

        cur_req = "R7";   // read coinciding with write returns old value
        op(1'b1, 1'b1, 8'h00, 32'h0000_00F0);
        op(1'b1, 1'b1, 8'h84, 32'h0F00_0000);
        rd(8'h00);
        rd(8'h84);
        idle(2);

        cur_req = "R2";   // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 11))
                0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
                4: a = 8'h80;  5: a = 8'h84;  6: a = 8'h88;  7: a = 8'h8C;
                8: a = 8'h10;  9: a = 8'h06;  10: a = 8'h90;
                default: a = 8'($urandom);
            endcase
            op(1'($urandom), 1'($urandom), a, $urandom);
        end

        cur_req = "R9";   // reset from a busy state
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h84, 32'h0000_FFFF);
        do_reset(2);
        read_all();
        idle(2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule